// File: doc/BRIEF.md
# Absolute Encoder Request Frame Transmitter

This block sends one request frame to an absolute position encoder that shares a half-duplex RS485 pair with the controller. A one-clock start pulse latches a 3-bit encoder address and a 5-bit command code. The block then switches the external line driver on and waits a settling time. It shifts out an 18-bit frame at a fixed bit rate derived from the system clock, and computes the 3-bit check code on the fly as the covered bits leave. After the stop bit has been held for a full bit time, the block switches the driver off and pulses done. A reply receiver can then take the line.

The bit period is `CLKS_PER_BIT` system clocks; the default of 40 gives 2.5 Mbit/s from a 100 MHz clock. The settling delay is `SETTLE_BITS` bit periods, with a default of one and a minimum of one. The frame fields, in line order, are start, sync, frame code, address, command, check code and stop.

Top module: `enc_req_tx`

## Requirements
- R1: After reset, and whenever no frame is in progress, `ser_o` is 1, `drv_en_o` is 0, `busy_o` is 0 and `done_o` is 0.
- R2: A `start_i` sampled high at a clock edge while `busy_o` is 0 sets `busy_o` and `drv_en_o` to 1 from that edge on. `ser_o` stays 1 during the settling time.
- R3: The first frame bit appears on `ser_o` exactly `SETTLE_BITS*CLKS_PER_BIT` clocks after the accepting edge. `drv_en_o` is 1 whenever `ser_o` is 0.
- R4: The frame has 18 bits. Each bit is held on `ser_o` for exactly `CLKS_PER_BIT` clocks.
- R5: The frame bit order (index 0 first on the line) is as follows. Index 0 is 0. Indices 1 to 3 are 0, 1, 0. Indices 4 and 5 are 0. Indices 6 to 8 carry `addr_i` bit 0, 1, 2. Indices 9 to 13 carry `cmd_i` bit 0 to 4. Indices 14 to 16 carry the check code. Index 17 is 1.
- R6: The check code is the remainder of the polynomial division by x^3+x+1, with a zero start value. It covers frame indices 4 to 13 in line order, the first bit sent being the highest power. Index 14 carries the x^2 coefficient, index 15 the x^1 coefficient and index 16 the x^0 coefficient.
- R7: `CLKS_PER_BIT` clocks after the stop bit appears, `drv_en_o` and `busy_o` fall and `done_o` is 1 for exactly one clock.
- R8: A `start_i` pulse while `busy_o` is 1 is ignored. The frame in progress keeps its content and timing, and no second frame follows it.
- R9: `addr_i` and `cmd_i` are sampled only at the accepting edge. Later changes do not alter the frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Request to send one frame |
| addr_i | input | 3 | Encoder address, sampled on accept |
| cmd_i | input | 5 | Command code, sampled on accept |
| ser_o | output | 1 | Serial data toward the line driver |
| drv_en_o | output | 1 | Line driver enable, 1 = transmit |
| busy_o | output | 1 | Frame in progress |
| done_o | output | 1 | One-clock pulse after the driver is released |

## Verification
The bench samples the first and last clock of every bit. An off-by-one in the bit timer or the settling counter therefore shows up as a bit that starts early or ends late. A check code sent in the wrong order, or one that also covers the sync bits, fails on most random address and command pairs, because the bench divides the message itself. A design that releases the driver before the stop bit has been held, or that pulses done for more than one clock, fails the end-of-frame checks. A design that restarts on a start pulse during a frame, or that reads the address and command inputs after accepting, fails when the bench pulses start and scrambles those inputs mid-frame.

// File: rtl/enc_req_pkg.sv
package enc_req_pkg;
  localparam int ADDR_W     = 3;
  localparam int CMD_W      = 5;
  localparam int CRC_W      = 3;
  localparam int FRAME_BITS = 18;
  localparam int IDX_W      = $clog2(FRAME_BITS);

  // line positions; the receiver decodes these, so they are fixed
  localparam int POS_SYNC   = 1;
  localparam int POS_FCODE  = 4;
  localparam int POS_ADDR   = 6;
  localparam int POS_CMD    = POS_ADDR + ADDR_W;
  localparam int POS_CRC    = POS_CMD + CMD_W;
  localparam int POS_STOP   = POS_CRC + CRC_W;

  // sync bits indexed by position after the start bit
  localparam logic [2:0] SYNC_BITS  = 3'b010;
  localparam logic [1:0] FCODE_BITS = 2'b00;
  // x^3 + x + 1 without the top term
  localparam logic [CRC_W-1:0] CRC_TAPS = 3'b011;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_SETTLE,
    ST_SHIFT
  } tx_state_e;
endpackage

// File: rtl/enc_bit_timer.sv
module enc_bit_timer #(
  parameter int CLKS_PER_BIT = 40
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  output logic tick
);
  localparam int CNT_W = (CLKS_PER_BIT > 1) ? $clog2(CLKS_PER_BIT) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(CLKS_PER_BIT - 1);

  logic [CNT_W-1:0] cnt;

  assign tick = run && (cnt == LAST);

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      cnt <= '0;
    end else if (cnt == LAST) begin
      cnt <= '0;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end

  AST_TIMER_RANGE: assert property (@(posedge clk) disable iff (rst)
    cnt <= LAST); // R4
  AST_TIMER_IDLE_ZERO: assert property (@(posedge clk) disable iff (rst)
    !run |=> (cnt == '0)); // R4
endmodule

// File: rtl/enc_crc3.sv
module enc_crc3 #(
  parameter int                 W    = 3,
  parameter logic [W-1:0]       TAPS = 3'b011
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clear,
  input  logic         en,
  input  logic         din,
  output logic [W-1:0] rem
);
  logic         fb;
  logic [W-1:0] nxt;

  always_comb begin
    fb  = din ^ rem[W-1];
    nxt = {rem[W-2:0], 1'b0} ^ (fb ? TAPS : '0);
  end

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      rem <= '0;
    end else if (en) begin
      rem <= nxt;
    end
  end

  AST_CRC_CLEARED: assert property (@(posedge clk) disable iff (rst)
    clear |=> (rem == '0)); // R6
  AST_CRC_HELD: assert property (@(posedge clk) disable iff (rst)
    (!clear && !en) |=> $stable(rem)); // R6
endmodule

// File: rtl/enc_frame_mux.sv
module enc_frame_mux
  import enc_req_pkg::*;
(
  input  logic [IDX_W-1:0]  idx,
  input  logic [ADDR_W-1:0] addr,
  input  logic [CMD_W-1:0]  cmd,
  input  logic [CRC_W-1:0]  crc,
  output logic              bit_o,
  output logic              covered
);
  int pos;

  always_comb begin
    pos     = int'(idx);
    bit_o   = 1'b1;
    covered = 1'b0;
    if (pos == 0) begin
      bit_o = 1'b0;
    end else if (pos < POS_FCODE) begin
      bit_o = SYNC_BITS[pos - POS_SYNC];
    end else if (pos < POS_ADDR) begin
      bit_o   = FCODE_BITS[pos - POS_FCODE];
      covered = 1'b1;
    end else if (pos < POS_CMD) begin
      bit_o   = addr[pos - POS_ADDR];
      covered = 1'b1;
    end else if (pos < POS_CRC) begin
      bit_o   = cmd[pos - POS_CMD];
      covered = 1'b1;
    end else if (pos < POS_STOP) begin
      // highest coefficient leaves first
      bit_o = crc[CRC_W - 1 - (pos - POS_CRC)];
    end else begin
      bit_o = 1'b1;
    end
  end
endmodule

// File: rtl/enc_req_tx.sv
module enc_req_tx
  import enc_req_pkg::*;
#(
  parameter int CLKS_PER_BIT = 40,
  parameter int SETTLE_BITS  = 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [CMD_W-1:0]  cmd_i,
  output logic              ser_o,
  output logic              drv_en_o,
  output logic              busy_o,
  output logic              done_o
);
  localparam int SET_N = (SETTLE_BITS < 1) ? 1 : SETTLE_BITS;
  localparam int SET_W = (SET_N > 1) ? $clog2(SET_N) : 1;
  localparam logic [SET_W-1:0] SET_LAST = SET_W'(SET_N - 1);
  localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(FRAME_BITS - 1);

  tx_state_e         state;
  logic [ADDR_W-1:0] addr_q;
  logic [CMD_W-1:0]  cmd_q;
  logic [SET_W-1:0]  set_cnt;
  logic [IDX_W-1:0]  bit_idx;
  logic [IDX_W-1:0]  next_idx;
  logic [CRC_W-1:0]  crc_rem;
  logic              tick;
  logic              accept;
  logic              load;
  logic              nxt_bit;
  logic              nxt_cov;

  assign accept   = start_i && (state == ST_IDLE);
  assign next_idx = (state == ST_SETTLE) ? '0 : bit_idx + 1'b1;
  assign load     = tick && ((state == ST_SETTLE && set_cnt == SET_LAST) ||
                             (state == ST_SHIFT && bit_idx != IDX_LAST));

  enc_bit_timer #(
    .CLKS_PER_BIT(CLKS_PER_BIT)
  ) i_timer (
    .clk (clk),
    .rst (rst),
    .run (state != ST_IDLE),
    .tick(tick)
  );

  enc_frame_mux i_mux (
    .idx    (next_idx),
    .addr   (addr_q),
    .cmd    (cmd_q),
    .crc    (crc_rem),
    .bit_o  (nxt_bit),
    .covered(nxt_cov)
  );

  enc_crc3 #(
    .W   (CRC_W),
    .TAPS(CRC_TAPS)
  ) i_crc (
    .clk  (clk),
    .rst  (rst),
    .clear(accept),
    .en   (load && nxt_cov),
    .din  (nxt_bit),
    .rem  (crc_rem)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= ST_IDLE;
      addr_q   <= '0;
      cmd_q    <= '0;
      set_cnt  <= '0;
      bit_idx  <= '0;
      ser_o    <= 1'b1;
      drv_en_o <= 1'b0;
      busy_o   <= 1'b0;
      done_o   <= 1'b0;
    end else begin
      done_o <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (accept) begin
            state    <= ST_SETTLE;
            addr_q   <= addr_i;
            cmd_q    <= cmd_i;
            set_cnt  <= '0;
            drv_en_o <= 1'b1;
            busy_o   <= 1'b1;
          end
        end
        ST_SETTLE: begin
          if (tick) begin
            if (set_cnt == SET_LAST) begin
              state   <= ST_SHIFT;
              bit_idx <= next_idx;
              ser_o   <= nxt_bit;
            end else begin
              set_cnt <= set_cnt + 1'b1;
            end
          end
        end
        ST_SHIFT: begin
          if (tick) begin
            if (bit_idx == IDX_LAST) begin
              state    <= ST_IDLE;
              ser_o    <= 1'b1;
              drv_en_o <= 1'b0;
              busy_o   <= 1'b0;
              done_o   <= 1'b1;
            end else begin
              bit_idx <= next_idx;
              ser_o   <= nxt_bit;
            end
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  AST_IDLE_LINE: assert property (@(posedge clk) disable iff (rst)
    !busy_o |-> (ser_o && !drv_en_o)); // R1
  AST_ACCEPT: assert property (@(posedge clk) disable iff (rst)
    (start_i && !busy_o) |=> (busy_o && drv_en_o)); // R2
  AST_LOW_NEEDS_DRIVER: assert property (@(posedge clk) disable iff (rst)
    !ser_o |-> drv_en_o); // R3
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (rst)
    done_o |=> !done_o); // R7
  AST_RELEASE_DONE: assert property (@(posedge clk) disable iff (rst)
    $fell(drv_en_o) |-> (done_o && ser_o)); // R7
  AST_FIELDS_HELD: assert property (@(posedge clk) disable iff (rst)
    busy_o |=> (!busy_o || ($stable(addr_q) && $stable(cmd_q)))); // R9
  AST_NO_RESTART: assert property (@(posedge clk) disable iff (rst)
    (busy_o && start_i) |=> (state != ST_SETTLE || $stable(set_cnt) || set_cnt != '0 || $past(state) == ST_SETTLE)); // R8
endmodule

// File: tb/test_enc_req_tx.sv
module test_enc_req_tx;
  localparam int N  = 40;
  localparam int S  = 1;
  localparam int SN = S * N;
  localparam int ENDJ = SN + 18 * N;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       start_i = 1'b0;
  logic [2:0] addr_i = '0;
  logic [4:0] cmd_i = '0;
  logic       ser_o, drv_en_o, busy_o, done_o;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  enc_req_tx #(.CLKS_PER_BIT(N), .SETTLE_BITS(S)) i_enc_req_tx (
    .clk(clk), .rst(rst), .start_i(start_i), .addr_i(addr_i), .cmd_i(cmd_i),
    .ser_o(ser_o), .drv_en_o(drv_en_o), .busy_o(busy_o), .done_o(done_o)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  // remainder of long division by 1011, first line bit = highest power
  function automatic logic [2:0] ref_crc(input logic [2:0] a, input logic [4:0] c);
    logic [12:0] d;
    d = {1'b0, 1'b0, a[0], a[1], a[2], c[0], c[1], c[2], c[3], c[4], 3'b000};
    for (int i = 12; i >= 3; i--) begin
      if (d[i]) d[i -: 4] = d[i -: 4] ^ 4'b1011;
    end
    return d[2:0];
  endfunction

  function automatic logic ref_bit(input int k, input logic [2:0] a, input logic [4:0] c);
    logic [2:0] r;
    r = ref_crc(a, c);
    if (k == 0) return 1'b0;
    if (k == 1 || k == 3) return 1'b0;
    if (k == 2) return 1'b1;
    if (k < 6) return 1'b0;
    if (k < 9) return a[k - 6];
    if (k < 14) return c[k - 9];
    if (k < 17) return r[16 - k];
    return 1'b1;
  endfunction

  function automatic string bit_req(input int k);
    if (k >= 14 && k <= 16) return "R6";
    return "R5";
  endfunction

  // disturb_j < 0: no mid-frame start pulse
  task automatic run_frame(input logic [2:0] a, input logic [4:0] c, input int disturb_j);
    @(negedge clk);
    start_i = 1'b1;
    addr_i  = a;
    cmd_i   = c;
    @(posedge clk);
    #1;
    start_i = 1'b0;
    addr_i  = 3'($urandom);        // R9: later input changes must not matter
    cmd_i   = 5'($urandom);
    for (int j = 0; j <= ENDJ + 3; j++) begin
      @(negedge clk);
      if (j == disturb_j) begin
        start_i = 1'b1;              // R8
        addr_i  = ~a;
        cmd_i   = ~c;
      end else begin
        start_i = 1'b0;
      end
      if (j == 0) begin
        check("R2 busy", int'(busy_o), 1);
        check("R2 drv_en", int'(drv_en_o), 1);
        check("R2 ser idle", int'(ser_o), 1);
      end
      if (j == SN - 1) check("R3 settle ser", int'(ser_o), 1);
      if (j >= SN && j < ENDJ) begin
        int k = (j - SN) / N;
        int o = (j - SN) % N;
        if (o == 0 || o == N - 1) begin
          check({bit_req(k), (o == 0) ? " bit start" : " R4 bit hold"},
                int'(ser_o), int'(ref_bit(k, a, c)));
          check("R3 drv_en during frame", int'(drv_en_o), 1);
        end
        if (o == N - 1 && k == 17) check("R7 done not early", int'(done_o), 0);
      end
      if (j == ENDJ) begin
        check("R7 drv_en released", int'(drv_en_o), 0);
        check("R7 busy cleared", int'(busy_o), 0);
        check("R7 done pulse", int'(done_o), 1);
        check("R7 ser idle", int'(ser_o), 1);
      end
      if (j == ENDJ + 1) check("R7 done one clock", int'(done_o), 0);
      if (j == ENDJ + 3) begin
        check("R8 no second frame", int'(busy_o), 0);
        check("R8 driver stays off", int'(drv_en_o), 0);
      end
    end
  endtask

  initial begin
    void'($urandom(32'h1234_5eed));
    repeat (4) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check("R1 reset ser", int'(ser_o), 1);
    check("R1 reset drv_en", int'(drv_en_o), 0);
    check("R1 reset busy", int'(busy_o), 0);
    check("R1 reset done", int'(done_o), 0);

    run_frame(3'b000, 5'b00000, -1);       // position request, all-zero code
    run_frame(3'b111, 5'b11111, -1);       // all ones
    run_frame(3'b101, 5'b01010, SN + 5);   // start pulse during the start bit
    run_frame(3'b010, 5'b10001, ENDJ - 1); // start pulse in the last stop clock
    run_frame(3'b001, 5'b00001, 2);        // start pulse during settling
    for (int i = 0; i < 20; i++) begin
      logic [2:0] a = 3'($urandom);
      logic [4:0] c = 5'($urandom);
      int dj = ($urandom % 3 == 0) ? int'($urandom % ENDJ) : -1;
      run_frame(a, c, dj);
    end
    // idle line with inputs toggling but no start
    for (int i = 0; i < 10; i++) begin
      @(negedge clk);
      addr_i = 3'($urandom);
      cmd_i  = 5'($urandom);
      check("R1 idle ser", int'(ser_o), 1);
    end
    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL R7 watchdog: actual hung expected frame end");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule